// File: doc/BRIEF.md
# Local Bus Burst Target

This block is the user-logic end of a synchronous 32-bit local bus with separate address and data lines, as driven by a PCI bridge. The bridge starts each transfer with an active-low address strobe. It holds write data on the shared data bus or waits for read data, and it flags the final data beat with an active-low last strobe. The target decodes its own window, which is the half of the address space where address bit 23 is zero. It holds a small word array and paces every beat itself by pulling an active-low ready after a fixed number of wait cycles.

Bursts of any length are accepted. The target keeps its own word pointer, which steps once per beat and wraps inside the array. After a set number of beats the target asserts an active-low burst-terminate together with ready, and the bridge must then restart with a fresh address strobe. Ready, burst-terminate and the data bus are driven only while an access is in progress and are high-impedance otherwise. The DMA and interrupt outputs are held inactive.

Top module: `lbus_target`

## Requirements
- R1: While reset is low and after it is released, with no access in progress, ready, burst-terminate and the data bus are all undriven (high impedance).
- R2: An address strobe seen while address bit 23 is 1 is ignored. No ready appears and no word of the array changes.
- R3: Before every data beat, ready stays high for exactly WAIT_CYC cycles. These are counted from the address-strobe cycle for the first beat and from the previous beat for later beats.
- R4: On a write beat, byte lane k (data bits 8k+7 down to 8k) of the addressed word is updated only when byte enable k is low. Other lanes keep their value.
- R5: On a read beat, the data bus carries the addressed word in the same cycle in which ready is low.
- R6: The word index is taken from address bits [2+log2(DEPTH)-1 : 2] only at the address strobe. It then advances by one per beat and wraps modulo DEPTH. Address changes during a burst have no effect.
- R7: A beat with the last strobe low ends the access. In the next cycle ready and burst-terminate are released.
- R8: Burst-terminate goes low together with ready on beat number MAX_BEATS of an access (counted from 1) and on no other beat. That beat ends the access.
- R9: The data bus is driven only during read beats. It is never driven in the cycle after a write beat.
- R10: Both DMA request outputs, both end-of-transfer outputs and the interrupt output are always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Active-low asynchronous reset from the bridge |
| la_i | input | 30 | Word address, bits 31 down to 2 |
| be_n_i | input | 4 | Active-low byte enables, one per byte lane |
| wr_i | input | 1 | High for write, low for read |
| ads_n_i | input | 1 | Active-low address strobe, marks the start of an access |
| blast_n_i | input | 1 | Active-low last-beat strobe |
| data_io | inout | 32 | Bidirectional data bus |
| ready_n_o | output | 1 | Active-low beat ready, tri-stated when idle |
| bterm_n_o | output | 1 | Active-low burst terminate, tri-stated when idle |
| dreq_n_o | output | 2 | DMA requests, held high |
| eot_n_o | output | 2 | DMA end-of-transfer, held high |
| int_n_o | output | 1 | Interrupt request, held high |

## Verification
Directed cases come first: a full-array burst write that must be split at MAX_BEATS, a burst that wraps from the top of the array to index 0, partial byte-enable writes, and a strobe outside the window. Together they separate wrap, lane masking, split timing and decode faults. Random accesses then follow, with random start index, length from 1 to 12, direction and byte enables. The address lines are scrambled during each burst, which shows whether the pointer is held internally. Each beat is checked for the number of wait cycles before it, for the burst-terminate value and, on reads, for the word. The check after each access shows whether the bus and strobes were released and whether a turnaround gap follows writes.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_BEAT = 2'd2
   } lbt_state_e;

   localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/lbt_regfile.sv
module lbt_regfile #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned LANES = DW / lbt_pkg::LANE_W
) (
   input  logic             clk,
   input  logic             we,
   input  logic [LANES-1:0] be_n,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   localparam int unsigned LW = lbt_pkg::LANE_W;

   // One storage array per byte lane, so each lane has a single writer.
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LW-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (we && !be_n[k]) begin
            lane_mem[addr] <= wdata[k*LW +: LW];
         end
      end

      assign rdata[k*LW +: LW] = lane_mem[addr];
   end

endmodule

// File: rtl/lbt_ctrl.sv
module lbt_ctrl
   import lbt_pkg::*;
#(
   parameter int unsigned AW        = 4,
   parameter int unsigned WAIT_CYC  = 1,
   parameter int unsigned MAX_BEATS = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ads_n,
   input  logic          blast_n,
   input  logic          wr,
   input  logic          hit,
   input  logic [AW-1:0] la_word,
   output logic          beat,
   output logic          bterm,
   output logic          busy,
   output logic          is_wr,
   output logic [AW-1:0] addr
);
   localparam int unsigned WCW    = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
   localparam int unsigned BCW    = $clog2(MAX_BEATS + 1);
   localparam int unsigned RELOAD = (WAIT_CYC > 0) ? WAIT_CYC - 1 : 0;
   localparam lbt_state_e  GAP_ST = (WAIT_CYC == 0) ? ST_BEAT : ST_WAIT;

   lbt_state_e     st;
   logic [WCW-1:0] wcnt;
   logic [BCW-1:0] bnum;
   logic           start;
   logic           last;

   assign start = (st == ST_IDLE) && !ads_n && hit;
   assign beat  = (st == ST_BEAT);
   assign bterm = beat && (bnum == BCW'(MAX_BEATS));
   assign last  = beat && (!blast_n || bterm);
   assign busy  = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         wcnt  <= '0;
         bnum  <= '0;
         addr  <= '0;
         is_wr <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  addr  <= la_word;
                  is_wr <= wr;
                  bnum  <= BCW'(1);
                  wcnt  <= WCW'(RELOAD);
                  st    <= GAP_ST;
               end
            end
            ST_WAIT: begin
               if (wcnt == '0) st <= ST_BEAT;
               else            wcnt <= wcnt - 1'b1;
            end
            ST_BEAT: begin
               if (last) begin
                  st <= ST_IDLE;
               end else begin
                  addr <= addr + 1'b1;
                  bnum <= bnum + 1'b1;
                  wcnt <= WCW'(RELOAD);
                  st   <= GAP_ST;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_DESELECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !ads_n && !hit) |=> (st == ST_IDLE)); // R2

   AST_BLAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && !blast_n) |=> !busy); // R7

   AST_SPLIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      bterm |=> (st == ST_IDLE)); // R8

   AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      beat |-> (bnum >= BCW'(1) && bnum <= BCW'(MAX_BEATS))); // R8

   if (WAIT_CYC > 0) begin : g_wait_chk
      AST_WAIT_BEFORE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
         (start || (beat && !last)) |=> !beat); // R3
   end

endmodule

// File: rtl/lbus_target.sv
module lbus_target #(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned WAIT_CYC  = 1,
   parameter int unsigned MAX_BEATS = 8,
   parameter int unsigned SEL_BIT   = 23,
   parameter int unsigned DMA_CH    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:2]       la_i,
   input  logic [3:0]        be_n_i,
   input  logic              wr_i,
   input  logic              ads_n_i,
   input  logic              blast_n_i,
   inout  wire  [31:0]       data_io,
   output logic              ready_n_o,
   output logic              bterm_n_o,
   output logic [DMA_CH-1:0] dreq_n_o,
   output logic [DMA_CH-1:0] eot_n_o,
   output logic              int_n_o
);
   localparam int unsigned DW = 32;
   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (SEL_BIT < 2 + AW || SEL_BIT > 31) begin : g_bad_sel
      $error("SEL_BIT must lie above the word index bits and below 32");
   end
   if (MAX_BEATS < 1) begin : g_bad_max
      $error("MAX_BEATS must be at least 1");
   end

   logic          beat;
   logic          bterm;
   logic          busy;
   logic          is_wr;
   logic [AW-1:0] addr;
   logic [DW-1:0] rdata;
   logic          rd_oe;
   logic          unused_la;

   assign unused_la = &{1'b0, la_i};

   lbt_ctrl #(
      .AW        (AW),
      .WAIT_CYC  (WAIT_CYC),
      .MAX_BEATS (MAX_BEATS)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ads_n   (ads_n_i),
      .blast_n (blast_n_i),
      .wr      (wr_i),
      .hit     (!la_i[SEL_BIT]),
      .la_word (la_i[2 +: AW]),
      .beat    (beat),
      .bterm   (bterm),
      .busy    (busy),
      .is_wr   (is_wr),
      .addr    (addr)
   );

   lbt_regfile #(
      .DW    (DW),
      .DEPTH (DEPTH)
   ) u_regs (
      .clk   (clk),
      .we    (beat && is_wr),
      .be_n  (be_n_i),
      .addr  (addr),
      .wdata (data_io),
      .rdata (rdata)
   );

   assign rd_oe     = beat && !is_wr;
   assign data_io   = rd_oe ? rdata : 'z;
   assign ready_n_o = busy ? !beat  : 1'bz;
   assign bterm_n_o = busy ? !bterm : 1'bz;

   assign dreq_n_o = '1;
   assign eot_n_o  = '1;
   assign int_n_o  = 1'b1;

   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      (beat && is_wr) |=> !rd_oe); // R9

endmodule

// File: tb/tb_lbus_target.sv
`timescale 1ns/1ps
module tb_lbus_target;
   localparam int DEPTH = 16;
   localparam int WAITS = 1;
   localparam int MAXB  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:2] la = '0;
   logic [3:0]  be_n = 4'hF;
   logic        wr = 1'b0;
   logic        ads_n = 1'b1;
   logic        blast_n = 1'b1;
   logic [31:0] tb_d = '0;
   logic        tb_oe = 1'b0;
   tri1  [31:0] data_w;
   tri1         ready_w;
   tri1         bterm_w;
   logic [1:0]  dreq_n, eot_n;
   logic        int_n;

   int checks = 0;
   int fails  = 0;
   logic [31:0] model [DEPTH];

   assign data_w = tb_oe ? tb_d : 'z;

   always #10 clk = ~clk;

   lbus_target #(.DEPTH(DEPTH), .WAIT_CYC(WAITS), .MAX_BEATS(MAXB), .SEL_BIT(23), .DMA_CH(2)) dut (
      .clk(clk), .rst_n(rst_n), .la_i(la), .be_n_i(be_n), .wr_i(wr),
      .ads_n_i(ads_n), .blast_n_i(blast_n), .data_io(data_w),
      .ready_n_o(ready_w), .bterm_n_o(bterm_w),
      .dreq_n_o(dreq_n), .eot_n_o(eot_n), .int_n_o(int_n));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] ben);
      logic [31:0] r = old;
      for (int k = 0; k < 4; k++) if (!ben[k]) r[k*8 +: 8] = nw[k*8 +: 8];
      return r;
   endfunction

   function automatic logic [31:2] word_addr(input int idx);
      logic [31:2] a = {$urandom, 2'b00} >> 2;
      a[23] = 1'b0;
      a[5:2] = idx[3:0];
      return a;
   endfunction

   // One access as the bridge would run it; returns the number of beats taken.
   task automatic access(input bit w, input int start, input int nbeats, input logic [3:0] ben, output int done);
      int  beat_i = 0;
      int  waits  = 0;
      bit  fin    = 0;
      logic [31:0] wd;
      @(negedge clk);
      ads_n = 1'b0; la = word_addr(start); wr = w; be_n = ben; blast_n = 1'b1;
      tb_oe = w; tb_d = $urandom;
      while (!fin) begin
         @(negedge clk);
         ads_n = 1'b0 ^ 1'b1;
         la = {$urandom, 2'b00} >> 2;          // R6: scrambled, must be ignored
         blast_n = (beat_i == nbeats - 1) ? 1'b0 : 1'b1;
         wd = $urandom;
         if (w) tb_d = wd;
         #1;
         if (ready_w === 1'b0) begin
            int idx = (start + beat_i) % DEPTH;
            chk(waits == WAITS, "R3 wait cycles", waits, WAITS);
            chk(bterm_w === ((beat_i == MAXB - 1) ? 1'b0 : 1'b1), "R8 burst terminate",
                {31'd0, bterm_w}, {31'd0, (beat_i != MAXB - 1)});
            if (w) model[idx] = merge(model[idx], wd, ben);
            else   chk(data_w === model[idx], "R5 R6 read data", data_w, model[idx]);
            fin = (beat_i == nbeats - 1) || (bterm_w === 1'b0);
            beat_i++;
            waits = 0;
         end else begin
            waits++;
            if (waits > WAITS + 4) begin
               chk(0, "R3 ready never came", waits, WAITS);
               fin = 1;
            end
         end
      end
      @(negedge clk);
      tb_oe = 1'b0; blast_n = 1'b1; wr = 1'b0;
      #1;
      chk(ready_w === 1'b1 && bterm_w === 1'b1, "R7 strobes released", {30'd0, ready_w, bterm_w}, 32'd3);
      if (w) chk(data_w === 32'hFFFF_FFFF, "R9 turnaround", data_w, 32'hFFFF_FFFF);
      else   chk(data_w === 32'hFFFF_FFFF, "R9 bus released", data_w, 32'hFFFF_FFFF);
      done = beat_i;
   endtask

   task automatic transfer(input bit w, input int start, input int nbeats, input logic [3:0] ben);
      int left = nbeats;
      int pos  = start;
      int got;
      while (left > 0) begin
         access(w, pos, left, ben, got);
         if (got == 0) break;
         if (left > MAXB) chk(got == MAXB, "R8 split point", got, MAXB);
         left -= got;
         pos = (pos + got) % DEPTH;
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      #1;
      chk(ready_w === 1'b1 && bterm_w === 1'b1 && data_w === 32'hFFFF_FFFF, "R1 reset idle",
          data_w, 32'hFFFF_FFFF);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); #1;
      chk(ready_w === 1'b1 && data_w === 32'hFFFF_FFFF, "R1 idle after reset", data_w, 32'hFFFF_FFFF);
      chk(dreq_n === 2'b11 && eot_n === 2'b11 && int_n === 1'b1, "R10 tie-offs",
          {27'd0, dreq_n, eot_n, int_n}, 32'h1F);

      // Fill the array: a 16-beat burst, split at MAXB (R8)
      transfer(1'b1, 0, DEPTH, 4'h0);
      transfer(1'b0, 0, DEPTH, 4'h0);

      // Wrap around the top of the array (R6)
      transfer(1'b1, DEPTH - 2, 4, 4'h0);
      transfer(1'b0, DEPTH - 2, 4, 4'h0);

      // Byte lanes (R4)
      transfer(1'b1, 5, 1, 4'b1010);
      transfer(1'b1, 6, 2, 4'b0111);
      transfer(1'b0, 5, 2, 4'h0);

      // Outside the window (R2)
      @(negedge clk);
      ads_n = 1'b0; la = word_addr(3); la[23] = 1'b1; wr = 1'b1; be_n = 4'h0;
      tb_oe = 1'b1; tb_d = ~model[3]; blast_n = 1'b0;
      @(negedge clk);
      ads_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1;
         chk(ready_w === 1'b1, "R2 no ready outside window", {31'd0, ready_w}, 32'd1);
         @(negedge clk);
      end
      tb_oe = 1'b0; blast_n = 1'b1; wr = 1'b0;
      transfer(1'b0, 3, 1, 4'h0);

      // Random mix
      for (int n = 0; n < 40; n++) begin
         bit w = $urandom_range(0, 1);
         transfer(w, $urandom_range(0, DEPTH - 1), $urandom_range(1, 12), 4'($urandom));
      end
      transfer(1'b0, 0, DEPTH, 4'h0);

      @(negedge clk); #1;
      chk(dreq_n === 2'b11 && eot_n === 2'b11 && int_n === 1'b1, "R10 tie-offs at end",
          {27'd0, dreq_n, eot_n, int_n}, 32'h1F);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule